// File: doc/BRIEF.md
# Beam Crossing Number Synchronization Checker

This block follows the beam-crossing number that goes with front-end data. It checks that number against the trigger number that arrives with every Level 1 accept. Two counters advance on every crossing strobe: a bunch counter and a turn counter. The bunch counter wraps at a programmable bunches-per-turn value, and each wrap advances the turn counter. The number of the current crossing is its turn and bunch, composed into 24 bits: the low 16 turn bits sit above the 8-bit bunch. On every strobe this number is pushed into a delay line whose depth equals the trigger latency in crossings. The value at the tail of the line is therefore the number of the crossing that the trigger framework is deciding on now.

When an accept arrives, the block compares its trigger number with the tail of the delay line. A difference points to a desynchronized counter or data FIFO. It raises a sticky error flag, which the trigger-framework link reports, and it bumps an 8-bit saturating mismatch counter. A 32-bit accept counter counts every accept. Comparison stays off until the delay line has been filled once after reset.

A small control state machine has three named states:
- **FILL**: entered at reset; the delay line is not yet full.
- **TRACK**: the line is full and no error is pending.
- **FAULT**: a mismatch has been seen.

Its transitions are:
- **fill_done**: FILL to TRACK, taken once the line is full.
- **miss**: TRACK or FILL to FAULT, taken on a compared accept that does not match.
- **clear**: FAULT to TRACK, taken on an error clear when no mismatch occurs in the same cycle.
- **rst**: any state to FILL.

Top module: `xsync_checker`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to zero after that edge: the counts, bunch, turn, `sync_error` and `check_armed`.
- R2: `bunch_id` rises by one at each clock edge where `xing_stb` is high. Without a strobe, `bunch_id` and `turn_count` hold.
- R3: A strobe whose next bunch value would reach `bunches_per_turn` sets `bunch_id` to 0 and adds one to `turn_count`. A setting of 0 or 1 makes every strobe such a wrap.
- R4: `accept_count` rises by one at each edge where `l1_accept` is high, whether or not the accept is compared.
- R5: `check_armed` goes high at the edge of the LATENCY-th strobe after reset. Accepts before that edge are not compared and never set `sync_error`.
- R6: The expected trigger number is {turn[15:0], bunch[7:0]} of the crossing LATENCY strobes before the current one. An armed accept that carries it leaves `sync_error` unchanged.
- R7: An armed accept whose `l1_trig_num` differs from the expected number sets `sync_error` at that edge. The flag stays set until it is cleared.
- R8: `err_clear` drops `sync_error` at the next edge. A mismatch in the same cycle wins, and the flag stays set.
- R9: `mismatch_count` rises by one for each mismatched armed accept and stays at 255 once it gets there. `err_clear` does not change it.
- R10: A reset in the middle of a run also drops `check_armed`, so the line must fill again before comparisons resume.
- R11: When an accept and a strobe share a cycle, the comparison uses the expected number from before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xing_stb | input | 1 | One-cycle pulse per beam crossing |
| bunches_per_turn | input | 8 | Bunch count per turn, where the bunch counter wraps |
| l1_accept | input | 1 | One-cycle Level 1 accept pulse |
| l1_trig_num | input | 24 | Trigger number sent with the accept: turn[15:0], bunch[7:0] |
| err_clear | input | 1 | Clears the sticky error flag |
| bunch_id | output | 8 | Current bunch number |
| turn_count | output | 32 | Current turn number |
| accept_count | output | 32 | Number of accepts since reset |
| mismatch_count | output | 8 | Saturating count of mismatched accepts |
| sync_error | output | 1 | Sticky desynchronization flag |
| check_armed | output | 1 | High once the delay line has filled after reset |

## Verification
Accepts carry the correct number at several points in a turn, including just past a bunch wrap. This separates a correct delay depth and wrap from an off-by-one in either. Wrong numbers with a bad bunch field and with a bad turn field show that both fields are compared. An accept that carries the pre-strobe and the post-strobe number in a strobe cycle pins down which value the compare uses. Accepts during fill, a clear that lands with a mismatch, a run of 260 bad accepts and a mid-run reset cover arming, priority, saturation and restart.

// File: rtl/xsync_pkg.sv
package xsync_pkg;

    // Checker control states
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_TRACK = 2'd1,
        ST_FAULT = 2'd2
    } chk_state_e;

    // Widths of the composite trigger number fields
    localparam int TRIG_TURN_W  = 16;
    localparam int TRIG_BUNCH_W = 8;
    localparam int TRIG_W       = TRIG_TURN_W + TRIG_BUNCH_W;

endpackage

// File: rtl/xsync_xing_ctr.sv
module xsync_xing_ctr #(
    parameter int TURN_W  = 32,
    parameter int BUNCH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stb,
    input  logic [BUNCH_W-1:0] bunches_per_turn,
    output logic [BUNCH_W-1:0] bunch_q,
    output logic [TURN_W-1:0]  turn_q
);

    logic [BUNCH_W:0] bunch_inc;
    logic             wrap;

    always_comb begin
        bunch_inc = {1'b0, bunch_q} + 1'b1;
        wrap      = (bunch_inc >= {1'b0, bunches_per_turn});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bunch_q <= '0;
            turn_q  <= '0;
        end else if (stb) begin
            if (wrap) begin
                bunch_q <= '0;
                turn_q  <= turn_q + 1'b1;
            end else begin
                bunch_q <= bunch_inc[BUNCH_W-1:0];
            end
        end
    end

    // R2
    hold_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(bunch_q) && $stable(turn_q)));

    // R3
    turn_moves_only_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && (turn_q != '1)) |=> ((turn_q == $past(turn_q)) || (bunch_q == '0)));

endmodule

// File: rtl/xsync_delay.sv
module xsync_delay #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             filled
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] stage_q [DEPTH];
    logic [CNT_W-1:0] fill_q;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)        stage_q[0] <= '0;
                    else if (shift) stage_q[0] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)        stage_q[gi] <= '0;
                    else if (shift) stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                            fill_q <= '0;
        else if (shift && fill_q != FULL_CNT) fill_q <= fill_q + 1'b1;
    end

    assign dout   = stage_q[DEPTH-1];
    assign filled = (fill_q == FULL_CNT);

    // R6
    tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(dout));

    // R5
    fill_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        filled |=> filled);

endmodule

// File: rtl/xsync_check_fsm.sv
module xsync_check_fsm
    import xsync_pkg::*;
#(
    parameter int NUM_W  = 24,
    parameter int ACC_W  = 32,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              filled,
    input  logic              accept,
    input  logic [NUM_W-1:0]  trig_num,
    input  logic [NUM_W-1:0]  expected,
    input  logic              err_clear,
    output logic              sync_error,
    output logic [ACC_W-1:0]  accept_count,
    output logic [MISS_W-1:0] mismatch_count
);

    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    chk_state_e state_q, state_d;
    logic       cmp_fail;

    assign cmp_fail = accept && filled && (trig_num != expected);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (cmp_fail)    state_d = ST_FAULT;
                else if (filled) state_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (cmp_fail)    state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (!cmp_fail && err_clear) state_d = ST_TRACK;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FILL;
        else     state_q <= state_d;
    end

    // Output counters
    always_ff @(posedge clk) begin
        if (rst) begin
            accept_count   <= '0;
            mismatch_count <= '0;
        end else begin
            if (accept)
                accept_count <= accept_count + 1'b1;
            if (cmp_fail && mismatch_count != MISS_MAX)
                mismatch_count <= mismatch_count + 1'b1;
        end
    end

    assign sync_error = (state_q == ST_FAULT);

    // R4
    accept_step_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (accept_count == $past(accept_count) + 1'b1));

    // R5
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!filled && !sync_error) |=> !sync_error);

    // R7
    error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_error && !err_clear) |=> sync_error);

    // R9
    miss_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (mismatch_count == MISS_MAX) |=> (mismatch_count == MISS_MAX));

    // R9
    miss_vs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !accept) |=> $stable(mismatch_count));

endmodule

// File: rtl/xsync_checker.sv
module xsync_checker
    import xsync_pkg::*;
#(
    parameter int TURN_W  = 32,
    parameter int BUNCH_W = TRIG_BUNCH_W,
    parameter int ACC_W   = 32,
    parameter int MISS_W  = 8,
    parameter int LATENCY = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xing_stb,
    input  logic [BUNCH_W-1:0] bunches_per_turn,
    input  logic               l1_accept,
    input  logic [TRIG_W-1:0]  l1_trig_num,
    input  logic               err_clear,
    output logic [BUNCH_W-1:0] bunch_id,
    output logic [TURN_W-1:0]  turn_count,
    output logic [ACC_W-1:0]   accept_count,
    output logic [MISS_W-1:0]  mismatch_count,
    output logic               sync_error,
    output logic               check_armed
);

    logic [TRIG_W-1:0] cur_num;
    logic [TRIG_W-1:0] tail_num;

    xsync_xing_ctr #(
        .TURN_W  (TURN_W),
        .BUNCH_W (BUNCH_W)
    ) u_ctr (
        .clk              (clk),
        .rst              (rst),
        .stb              (xing_stb),
        .bunches_per_turn (bunches_per_turn),
        .bunch_q          (bunch_id),
        .turn_q           (turn_count)
    );

    assign cur_num = {turn_count[TRIG_TURN_W-1:0], bunch_id};

    xsync_delay #(
        .WIDTH (TRIG_W),
        .DEPTH (LATENCY)
    ) u_delay (
        .clk    (clk),
        .rst    (rst),
        .shift  (xing_stb),
        .din    (cur_num),
        .dout   (tail_num),
        .filled (check_armed)
    );

    xsync_check_fsm #(
        .NUM_W  (TRIG_W),
        .ACC_W  (ACC_W),
        .MISS_W (MISS_W)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .filled         (check_armed),
        .accept         (l1_accept),
        .trig_num       (l1_trig_num),
        .expected       (tail_num),
        .err_clear      (err_clear),
        .sync_error     (sync_error),
        .accept_count   (accept_count),
        .mismatch_count (mismatch_count)
    );

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!sync_error && !check_armed && accept_count == '0 && turn_count == '0));

    // R7
    mismatch_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_accept && check_armed && l1_trig_num != tail_num) |=> sync_error);

    // R6
    match_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_accept && check_armed && l1_trig_num == tail_num && !sync_error) |=> !sync_error);

endmodule

// File: tb/xsync_checker_bench.sv
module xsync_checker_bench;

    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xing_stb = 1'b0;
    logic [7:0]  bunches_per_turn = 8'd5;
    logic        l1_accept = 1'b0;
    logic [23:0] l1_trig_num = '0;
    logic        err_clear = 1'b0;
    logic [7:0]  bunch_id;
    logic [31:0] turn_count;
    logic [31:0] accept_count;
    logic [7:0]  mismatch_count;
    logic        sync_error;
    logic        check_armed;

    int vectors = 0;
    int fails   = 0;
    int n_stb   = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    xsync_checker #(.LATENCY(LAT)) u_xsync_checker (
        .clk(clk), .rst(rst), .xing_stb(xing_stb), .bunches_per_turn(bunches_per_turn),
        .l1_accept(l1_accept), .l1_trig_num(l1_trig_num), .err_clear(err_clear),
        .bunch_id(bunch_id), .turn_count(turn_count), .accept_count(accept_count),
        .mismatch_count(mismatch_count), .sync_error(sync_error), .check_armed(check_armed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Crossing number of the crossing with linear index idx since reset
    function automatic logic [23:0] xnum(input int idx);
        int eff;
        eff = (bunches_per_turn < 2) ? 1 : int'(bunches_per_turn);
        return {16'(idx / eff), 8'(idx % eff)};
    endfunction

    task automatic tick(input bit s, input bit a, input logic [23:0] t, input bit c);
        xing_stb = s; l1_accept = a; l1_trig_num = t; err_clear = c;
        @(posedge clk); #1;
        xing_stb = 0; l1_accept = 0; err_clear = 0;
        if (s) n_stb++;
    endtask

    task automatic do_reset(input logic [7:0] bpt);
        bunches_per_turn = bpt;
        rst = 1;
        tick(0, 0, '0, 0);
        tick(0, 0, '0, 0);
        rst = 0;
        n_stb = 0;
    endtask

    task automatic strobes(input int k);
        for (int i = 0; i < k; i++) begin
            tick(1, 0, '0, 0);
            tick(0, 0, '0, 0);
        end
    endtask

    task automatic t_reset;
        do_reset(8'd5);
        chk("R1 bunch", bunch_id, 0);
        chk("R1 turn", turn_count, 0);
        chk("R1 acc", accept_count, 0);
        chk("R1 miss", mismatch_count, 0);
        chk("R1 err", sync_error, 0);
        chk("R1 armed", check_armed, 0);
    endtask

    task automatic t_count;
        do_reset(8'd5);
        strobes(3);
        chk("R2 bunch after 3", bunch_id, 3);
        tick(0, 0, '0, 0);
        chk("R2 hold", bunch_id, 3);
        strobes(9);
        chk("R3 bunch after 12", bunch_id, 2);
        chk("R3 turn after 12", turn_count, 2);
        do_reset(8'd0);
        strobes(3);
        chk("R3 bpt0 bunch", bunch_id, 0);
        chk("R3 bpt0 turn", turn_count, 3);
    endtask

    task automatic t_fill;
        do_reset(8'd5);
        strobes(LAT - 1);
        chk("R5 not armed", check_armed, 0);
        tick(0, 1, 24'hABCDEF, 0);
        chk("R5 no compare in fill", sync_error, 0);
        chk("R4 acc in fill", accept_count, 1);
        tick(1, 0, '0, 0);
        chk("R5 armed at LAT", check_armed, 1);
    endtask

    task automatic t_match;
        do_reset(8'd5);
        strobes(LAT);
        tick(0, 1, xnum(n_stb - LAT), 0);
        chk("R6 match at arm", sync_error, 0);
        strobes(10);
        tick(0, 1, xnum(n_stb - LAT), 0);
        chk("R6 match past wrap", sync_error, 0);
        chk("R4 acc count", accept_count, 2);
        chk("R9 no miss", mismatch_count, 0);
    endtask

    task automatic t_mismatch;
        // continues from t_match
        tick(0, 1, xnum(n_stb - LAT) ^ 24'h000001, 0);
        chk("R7 bad bunch sets err", sync_error, 1);
        chk("R9 miss one", mismatch_count, 1);
        strobes(2);
        tick(0, 1, xnum(n_stb - LAT), 0);
        chk("R7 sticky", sync_error, 1);
        tick(0, 0, '0, 1);
        chk("R8 clear", sync_error, 0);
        chk("R9 clear keeps miss", mismatch_count, 1);
        tick(0, 1, xnum(n_stb - LAT) ^ 24'h010000, 0);
        chk("R7 bad turn sets err", sync_error, 1);
        tick(0, 1, 24'h000000 ^ ~xnum(n_stb - LAT), 1);
        chk("R8 mismatch beats clear", sync_error, 1);
        chk("R9 miss three", mismatch_count, 3);
    endtask

    task automatic t_same_cycle;
        do_reset(8'd5);
        strobes(LAT + 4);
        tick(1, 1, xnum(n_stb - LAT), 0);
        chk("R11 pre-strobe number matches", sync_error, 0);
        tick(1, 1, xnum(n_stb - LAT + 1), 0);
        chk("R11 post-strobe number mismatches", sync_error, 1);
    endtask

    task automatic t_saturate;
        do_reset(8'd5);
        strobes(LAT);
        for (int i = 0; i < 260; i++) tick(0, 1, 24'hFFFFFF, 0);
        chk("R9 saturate", mismatch_count, 255);
        chk("R4 acc 260", accept_count, 260);
    endtask

    task automatic t_mid_reset;
        strobes(2);
        do_reset(8'd5);
        chk("R10 armed cleared", check_armed, 0);
        chk("R10 err cleared", sync_error, 0);
        chk("R10 miss cleared", mismatch_count, 0);
        tick(0, 1, 24'h123456, 0);
        chk("R10 no compare after reset", sync_error, 0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_fill();
        t_match();
        t_mismatch();
        t_same_cycle();
        t_saturate();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule